// File: doc/BRIEF.md
# Banked GPIO Controller with Test Override

This block manages 24 general-purpose pins, split into two banks of twelve. Each pin carries a direction, an output value and a pull choice (none, up or down). All of these live in a small register file that software writes and reads through a flat register port. Pin levels are brought back through a two-flop synchronizer so that software can read them.

Bank A pins can each be handed to an external peripheral, which then supplies the output data and the output enable. Bank B pins are plain GPIO in normal operation. When the test-mode input is high, five fixed Bank B pins become a JTAG port. Three of them turn into inputs that feed the clock, mode-select and data-in lines. The other two are driven from the test data-out and its enable.

A power-down input overrides everything else. It puts every pad into high impedance with no pull. It does not touch the registers, so when power-down ends the pads return to the settings held before it. The block drives the pads only through three controls per pin: output enable, output data and pull enables.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: The register address is 4 bits. Bit 3 selects the bank: 0 is Bank A (pins 0 to 11) and 1 is Bank B (pins 12 to 23). Bits 2:0 select the field: 0 direction (1 = output), 1 output value, 2 pull enable, 3 pull select (1 = up, 0 = down), 4 alternate select, 5 synchronized input (read-only). Each field holds one bit per pin of the bank. Field codes 6 and 7 read as zero.
- R2: When no override applies, pad_oe_o follows the direction bit and pad_do_o follows the output bit. pad_pu_o is pull enable AND pull select, and pad_pd_o is pull enable AND NOT pull select. No pin ever has both pulls on.
- R3: While rst_ni is low, every register clears to zero. As a result, every pin is an input with no pull and outputs 0.
- R4: While pwr_dn_i is high, every pad has its output enable, output data, pull-up and pull-down all at 0, whatever the registers hold.
- R5: Power-down does not change the registers. After pwr_dn_i falls, both the readback and the pads return to their pre-power-down values.
- R6: A Bank A pin whose alternate-select bit is 1 takes pad_oe_o from alt_oe_i and pad_do_o from alt_do_i. Its pulls still come from its registers. The Bank B alternate-select field keeps no state: writes to it have no effect and it reads as 0.
- R7: With test_mode_i high and pwr_dn_i low, Bank B pins 2, 3 and 4 (pads 14, 15 and 16) are inputs with no pull and output data 0. jtag_tck_o, jtag_tms_o and jtag_tdi_o follow pad_in_i[14], [15] and [16] without a register in between. Outside test mode these three outputs are 0.
- R8: With test_mode_i high and pwr_dn_i low, Bank B pins 5 and 6 (pads 17 and 18) take output enable from jtag_tdo_en_i and output data from jtag_tdo_i, with no pull.
- R9: In test mode, all Bank A pins and Bank B pins 0, 1 and 7 to 11 behave exactly as in R2 and R6.
- R10: Power-down overrides test mode. With both inputs high, the pads follow R4 and the three JTAG outputs are 0.
- R11: A read of the input field returns the pad_in_i bits of that bank as they were two rising clock edges earlier.
- R12: Writes to the input field have no effect on what that field reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Bank (bit 3) and field (bits 2:0) |
| reg_wdata_i | input | BANK_W | Write data, one bit per pin |
| reg_rdata_o | output | BANK_W | Combinational read data for reg_addr_i |
| pwr_dn_i | input | 1 | Power-down override |
| test_mode_i | input | 1 | Test-mode JTAG remap of Bank B |
| alt_oe_i | input | BANK_W | Peripheral output enables for Bank A |
| alt_do_i | input | BANK_W | Peripheral output data for Bank A |
| pad_in_i | input | 2*BANK_W | Pad input levels |
| pad_oe_o | output | 2*BANK_W | Pad output enables |
| pad_do_o | output | 2*BANK_W | Pad output data |
| pad_pu_o | output | 2*BANK_W | Pad pull-up enables |
| pad_pd_o | output | 2*BANK_W | Pad pull-down enables |
| jtag_tck_o | output | 1 | Test clock taken from Bank B pin 2 |
| jtag_tms_o | output | 1 | Test mode select taken from Bank B pin 3 |
| jtag_tdi_o | output | 1 | Test data in taken from Bank B pin 4 |
| jtag_tdo_i | input | 1 | Test data out to Bank B pins 5 and 6 |
| jtag_tdo_en_i | input | 1 | Enable for test data out |

## Verification
The bench uses the default BANK_W of 12, which covers every pin of both banks and both JTAG-remapped ranges. Sixteen arithmetic register patterns, together with varied peripheral, pad-input and test-port values, are run through each mode in turn: normal, test, power-down over test, power-down alone, and recovery. This reaches every combination of the four override paths on every pin. Separate steps cover the two-edge input latency, writes to the read-only field, and the unused field codes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    FLD_DIR  = 3'd0,
    FLD_OUT  = 3'd1,
    FLD_PEN  = 3'd2,
    FLD_PSEL = 3'd3,
    FLD_ALT  = 3'd4,
    FLD_IN   = 3'd5
  } fld_e;

  // Bank B pin positions taken over in test mode
  localparam int unsigned TCK_IDX  = 2;
  localparam int unsigned TMS_IDX  = 3;
  localparam int unsigned TDI_IDX  = 4;
  localparam int unsigned TDO0_IDX = 5;
  localparam int unsigned TDO1_IDX = 6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W       = 12,
  parameter bit          HAS_ALT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  fld_e         fld_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pen_o,
  output logic [W-1:0] psel_o,
  output logic [W-1:0] alt_o,
  output logic [W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      out_o  <= '0;
      pen_o  <= '0;
      psel_o <= '0;
    end else if (we_i) begin
      case (fld_i)
        FLD_DIR:  dir_o  <= wdata_i;
        FLD_OUT:  out_o  <= wdata_i;
        FLD_PEN:  pen_o  <= wdata_i;
        FLD_PSEL: psel_o <= wdata_i;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_ALT) begin : g_alt
      logic [W-1:0] alt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       alt_q <= '0;
        else if (we_i && fld_i == FLD_ALT) alt_q <= wdata_i;
      end
      assign alt_o = alt_q;
    end else begin : g_no_alt
      assign alt_o = '0;
    end
  endgenerate

  always_comb begin
    case (fld_i)
      FLD_DIR:  rdata_o = dir_o;
      FLD_OUT:  rdata_o = out_o;
      FLD_PEN:  rdata_o = pen_o;
      FLD_PSEL: rdata_o = psel_o;
      FLD_ALT:  rdata_o = alt_o;
      FLD_IN:   rdata_o = in_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int unsigned W       = 12,
  parameter bit          IS_TEST = 1'b0
) (
  input  logic         pdn_i,
  input  logic         tm_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] pen_i,
  input  logic [W-1:0] psel_i,
  input  logic [W-1:0] alt_i,
  input  logic [W-1:0] alt_oe_i,
  input  logic [W-1:0] alt_do_i,
  input  logic         tdo_i,
  input  logic         tdo_en_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] do_o,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] pd_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam bit TIN  = IS_TEST && (i == TCK_IDX || i == TMS_IDX || i == TDI_IDX);
    localparam bit TOUT = IS_TEST && (i == TDO0_IDX || i == TDO1_IDX);

    always_comb begin
      oe_o[i] = dir_i[i];
      do_o[i] = out_i[i];
      pu_o[i] = pen_i[i] & psel_i[i];
      pd_o[i] = pen_i[i] & ~psel_i[i];
      if (alt_i[i]) begin
        oe_o[i] = alt_oe_i[i];
        do_o[i] = alt_do_i[i];
      end
      if (tm_i && TIN) begin
        oe_o[i] = 1'b0;
        do_o[i] = 1'b0;
        pu_o[i] = 1'b0;
        pd_o[i] = 1'b0;
      end
      if (tm_i && TOUT) begin
        oe_o[i] = tdo_en_i;
        do_o[i] = tdo_i;
        pu_o[i] = 1'b0;
        pd_o[i] = 1'b0;
      end
      if (pdn_i) begin
        oe_o[i] = 1'b0;
        do_o[i] = 1'b0;
        pu_o[i] = 1'b0;
        pd_o[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned BANK_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [3:0]          reg_addr_i,
  input  logic [BANK_W-1:0]   reg_wdata_i,
  output logic [BANK_W-1:0]   reg_rdata_o,
  input  logic                pwr_dn_i,
  input  logic                test_mode_i,
  input  logic [BANK_W-1:0]   alt_oe_i,
  input  logic [BANK_W-1:0]   alt_do_i,
  input  logic [2*BANK_W-1:0] pad_in_i,
  output logic [2*BANK_W-1:0] pad_oe_o,
  output logic [2*BANK_W-1:0] pad_do_o,
  output logic [2*BANK_W-1:0] pad_pu_o,
  output logic [2*BANK_W-1:0] pad_pd_o,
  output logic                jtag_tck_o,
  output logic                jtag_tms_o,
  output logic                jtag_tdi_o,
  input  logic                jtag_tdo_i,
  input  logic                jtag_tdo_en_i
);
  localparam int unsigned NBANK = 2;
  localparam int unsigned NPINS = NBANK * BANK_W;

  logic [NPINS-1:0]  pin_sync;
  logic [BANK_W-1:0] bank_rdata [NBANK];
  fld_e              fld;
  logic              tm_act;

  assign fld    = fld_e'(reg_addr_i[2:0]);
  assign tm_act = test_mode_i & ~pwr_dn_i;

  gpio_sync #(.W(NPINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_W;
    logic [BANK_W-1:0] dir, out, pen, psel, alt;

    gpio_bank_regs #(.W(BANK_W), .HAS_ALT(b == 0)) i_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i && (reg_addr_i[3] == 1'(b))),
      .fld_i   (fld),
      .wdata_i (reg_wdata_i),
      .in_i    (pin_sync[LO +: BANK_W]),
      .dir_o   (dir),
      .out_o   (out),
      .pen_o   (pen),
      .psel_o  (psel),
      .alt_o   (alt),
      .rdata_o (bank_rdata[b])
    );

    gpio_pad_mux #(.W(BANK_W), .IS_TEST(b == 1)) i_mux (
      .pdn_i    (pwr_dn_i),
      .tm_i     (test_mode_i),
      .dir_i    (dir),
      .out_i    (out),
      .pen_i    (pen),
      .psel_i   (psel),
      .alt_i    (alt),
      .alt_oe_i ((b == 0) ? alt_oe_i : '0),
      .alt_do_i ((b == 0) ? alt_do_i : '0),
      .tdo_i    (jtag_tdo_i),
      .tdo_en_i (jtag_tdo_en_i),
      .oe_o     (pad_oe_o[LO +: BANK_W]),
      .do_o     (pad_do_o[LO +: BANK_W]),
      .pu_o     (pad_pu_o[LO +: BANK_W]),
      .pd_o     (pad_pd_o[LO +: BANK_W])
    );
  end

  assign reg_rdata_o = bank_rdata[reg_addr_i[3]];

  // JTAG inputs bypass the synchronizer: the test clock must not be delayed
  assign jtag_tck_o = tm_act & pad_in_i[BANK_W + TCK_IDX];
  assign jtag_tms_o = tm_act & pad_in_i[BANK_W + TMS_IDX];
  assign jtag_tdi_o = tm_act & pad_in_i[BANK_W + TDI_IDX];
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk #(
  parameter int unsigned BANK_W = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [3:0]          reg_addr_i,
  input logic [BANK_W-1:0]   reg_rdata_o,
  input logic                pwr_dn_i,
  input logic                test_mode_i,
  input logic [2*BANK_W-1:0] pad_in_i,
  input logic [2*BANK_W-1:0] pad_oe_o,
  input logic [2*BANK_W-1:0] pad_do_o,
  input logic [2*BANK_W-1:0] pad_pu_o,
  input logic [2*BANK_W-1:0] pad_pd_o,
  input logic                jtag_tck_o,
  input logic                jtag_tms_o,
  input logic                jtag_tdi_o,
  input logic                jtag_tdo_i,
  input logic                jtag_tdo_en_i
);
  localparam int unsigned B = BANK_W;
  logic [1:0] up_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  always_comb begin
    if (rst_ni == 1'b0) begin
      p_reset_idle_r3: assert ((pad_oe_o | pad_pu_o | pad_pd_o) == '0);
    end
  end

  p_pull_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_pd_o) == '0);

  p_pdn_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |-> (pad_oe_o | pad_do_o | pad_pu_o | pad_pd_o) == '0);

  p_jtag_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && !pwr_dn_i) |-> (pad_oe_o[B+4 -: 3] == 3'b0 &&
      {jtag_tdi_o, jtag_tms_o, jtag_tck_o} == pad_in_i[B+4 -: 3]));

  p_jtag_tdo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && !pwr_dn_i) |-> (pad_oe_o[B+6 -: 2] == {2{jtag_tdo_en_i}} &&
      pad_do_o[B+6 -: 2] == {2{jtag_tdo_i}}));

  p_pdn_over_test_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |-> !(jtag_tck_o || jtag_tms_o || jtag_tdi_o));

  p_in_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd2 && reg_addr_i == 4'd5) |-> reg_rdata_o == $past(pad_in_i[B-1:0], 2));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.BANK_W(BANK_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_addr_i    (reg_addr_i),
  .reg_rdata_o   (reg_rdata_o),
  .pwr_dn_i      (pwr_dn_i),
  .test_mode_i   (test_mode_i),
  .pad_in_i      (pad_in_i),
  .pad_oe_o      (pad_oe_o),
  .pad_do_o      (pad_do_o),
  .pad_pu_o      (pad_pu_o),
  .pad_pd_o      (pad_pd_o),
  .jtag_tck_o    (jtag_tck_o),
  .jtag_tms_o    (jtag_tms_o),
  .jtag_tdi_o    (jtag_tdi_o),
  .jtag_tdo_i    (jtag_tdo_i),
  .jtag_tdo_en_i (jtag_tdo_en_i)
);

// File: tb/test_gpio_banked_ctrl.sv
module test_gpio_banked_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int N = 2 * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic pdn = 1'b0, tm = 1'b0;
  logic [W-1:0] aoe = '0, ado = '0;
  logic [N-1:0] pin = '0, oe, dq, pu, pd;
  logic tck, tms, tdi, tdo = 1'b0, tdo_en = 1'b0;

  int errors = 0, checks = 0;
  logic [W-1:0] m [2][5];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_banked_ctrl #(.BANK_W(W)) i_gpio_banked_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pwr_dn_i(pdn), .test_mode_i(tm),
    .alt_oe_i(aoe), .alt_do_i(ado), .pad_in_i(pin), .pad_oe_o(oe),
    .pad_do_o(dq), .pad_pu_o(pu), .pad_pd_o(pd), .jtag_tck_o(tck),
    .jtag_tms_o(tms), .jtag_tdi_o(tdi), .jtag_tdo_i(tdo), .jtag_tdo_en_i(tdo_en)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int v, input int f, input int b);
    int unsigned x;
    x = (v * 37 + f * 113 + b * 71 + 5) * 32'h9E3779B1;
    return x[23:12];
  endfunction

  task automatic wr(input int b, input int f, input logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = {1'(b), 3'(f)}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int b, input int f, output logic [W-1:0] d);
    @(negedge clk);
    addr = {1'(b), 3'(f)};
    #1 d = rdata;
  endtask

  // Expected pad vector {oe, do, pu, pd} from the requirements
  function automatic logic [4*N-1:0] exp_pads();
    logic [N-1:0] eoe, edo, epu, epd;
    for (int p = 0; p < N; p++) begin
      int b, i;
      b = p / W; i = p % W;
      eoe[p] = m[b][0][i]; edo[p] = m[b][1][i];
      epu[p] = m[b][2][i] & m[b][3][i];
      epd[p] = m[b][2][i] & ~m[b][3][i];
      if (b == 0 && m[0][4][i]) begin eoe[p] = aoe[i]; edo[p] = ado[i]; end
      if (tm && b == 1 && i >= 2 && i <= 4) begin
        eoe[p] = 0; edo[p] = 0; epu[p] = 0; epd[p] = 0;
      end
      if (tm && b == 1 && (i == 5 || i == 6)) begin
        eoe[p] = tdo_en; edo[p] = tdo; epu[p] = 0; epd[p] = 0;
      end
      if (pdn) begin eoe[p] = 0; edo[p] = 0; epu[p] = 0; epd[p] = 0; end
    end
    return {eoe, edo, epu, epd};
  endfunction

  task automatic chk_pads(input string req);
    #1 chk(req, 128'({oe, dq, pu, pd}), 128'(exp_pads()));
  endtask

  task automatic chk_readback(input string req);
    logic [W-1:0] d;
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 5; f++) begin
        rd(b, f, d);
        chk(req, 128'(d), 128'(m[b][f]));
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    for (int b = 0; b < 2; b++) for (int f = 0; f < 5; f++) m[b][f] = '0;
    pin = 24'hABC123;
    #(CLK_PERIOD * 2 + 2);
    chk("R3 pads in reset", 128'({oe, pu, pd, dq}), 128'(0));
    @(negedge clk); rst_n = 1'b1;
    chk_readback("R3 regs after reset");
    chk_pads("R3 pads after reset");

    for (int v = 0; v < 16; v++) begin
      aoe = pat(v, 6, 0); ado = pat(v, 7, 0);
      pin = {pat(v, 8, 1), pat(v, 8, 0)};
      tdo = v[0]; tdo_en = v[1];
      for (int b = 0; b < 2; b++)
        for (int f = 0; f < 5; f++) begin
          wr(b, f, pat(v, f, b));
          if (!(b == 1 && f == 4)) m[b][f] = pat(v, f, b);
        end
      chk_readback("R1,R6 readback");
      tm = 1'b0; pdn = 1'b0;
      chk_pads("R2,R6 normal pads");
      tm = 1'b1;
      chk_pads("R7,R8,R9 test pads");
      chk("R7 jtag inputs", 128'({tck, tms, tdi}), 128'({pin[W+2], pin[W+3], pin[W+4]}));
      pdn = 1'b1;
      chk_pads("R4,R10 power-down over test");
      chk("R10 jtag off", 128'({tck, tms, tdi}), 128'(0));
      tm = 1'b0;
      chk_pads("R4 power-down");
      chk("R7 jtag off outside test", 128'({tck, tms, tdi}), 128'(0));
      @(negedge clk); pdn = 1'b0;
      chk_pads("R5 pads restored");
      chk_readback("R5 regs retained");
    end

    // Input synchronizer latency
    for (int b = 0; b < 2; b++) begin
      @(negedge clk); addr = {1'(b), 3'd5};
      pin = '0;
      repeat (3) @(negedge clk);
      pin = {W{b == 0 ? 2'b01 : 2'b10}} ;
      @(negedge clk); #1 chk("R11 one edge old", 128'(rdata), 128'(0));
      @(negedge clk); #1 chk("R11 two edges new", 128'(rdata), 128'(pin[b*W +: W]));
      wr(b, 5, ~pin[b*W +: W]);
      rd(b, 5, d);
      chk("R12 input write ignored", 128'(d), 128'(pin[b*W +: W]));
    end

    for (int f = 6; f < 8; f++) begin
      rd(0, f, d); chk("R1 unused field A", 128'(d), 128'(0));
      rd(1, f, d); chk("R1 unused field B", 128'(d), 128'(0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule